// File: doc/BRIEF.md
# Pulse Request Acknowledge Responder

This block answers single-cycle request pulses with single-cycle acknowledge pulses on the same clock. Each accepted request is placed in an in-order queue, together with a processing delay of 0 to 10 cycles. The delay comes either from an internal pseudo-random generator or, for testing, from an input port. A request waits until it reaches the head of the queue and its delay has run out. The block then emits one acknowledge, provided at least three cycles have passed since the previous acknowledge started.

The number of requests still waiting for an answer is shown on a registered count output. The queue holds up to 32 entries. A request that arrives while the queue is full is thrown away and raises a sticky error flag. Requests are expected to arrive no more often than one in three cycles. Reset is synchronous and active high.

Top module: `pulse_ack_responder`

## Requirements
- R1: `ack_o` is high for exactly one cycle at a time. Two acknowledges start at least 3 cycles apart, so an ack in cycle a allows the next one no earlier than cycle a+3.
- R2: Every accepted request gets exactly one acknowledge. Acknowledges come out in the order the requests arrived.
- R3: With `dly_sel_i`=1, a request in cycle c reaching an empty queue with spacing satisfied gives an ack in cycle c+d+3, where d is `dly_ext_i`. A queued request whose predecessor acked in cycle a acks in cycle max(a+d+2, a+3), or later if it arrived later.
- R4: A `dly_ext_i` value above 10 behaves as 10. With the internal source selected, every delay lies between 0 and 10.
- R5: `pending_o` rises in the cycle after a request and falls in the cycle in which its ack is high. When a request and an ack would change it at the same clock edge, it stays unchanged.
- R6: A request seen while `pending_o` is 32 is dropped and sets `err_o`. `err_o` stays high until reset, and `pending_o` never exceeds 32.
- R7: Reset is sampled at the clock edge. In the cycle after any edge with `rst` high, `ack_o`, `pending_o` and `err_o` are 0. The queue and the spacing timer are also cleared.
- R8: `dly_sel_i`=1 takes the delay from `dly_ext_i`, and `dly_sel_i`=0 takes it from the internal generator. The select is sampled together with each request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Single-cycle request pulse |
| dly_sel_i | input | 1 | 1: delay from `dly_ext_i`; 0: internal pseudo-random delay |
| dly_ext_i | input | DLY_W (4) | Test delay value, clamped to MAX_DLY |
| ack_o | output | 1 | Single-cycle acknowledge pulse |
| pending_o | output | CNT_W (6) | Number of unanswered accepted requests |
| err_o | output | 1 | Sticky flag: a request was dropped because the queue was full |

## Verification
Two things can land on the same clock edge: a new request being pushed and the head request being popped as its acknowledge fires. This happens naturally when requests arrive every three cycles while acknowledges are held back by delays of two or more. It also happens when the queue is full, where a pop and a dropped push can coincide. A behavioural queue model in the bench predicts the exact ack cycle and the pending count on every cycle. Any double count, lost pop or wrongly accepted push then shows up as a count or ack mismatch.

// File: rtl/pra_pkg.sv
package pra_pkg;

  // Source of the per-request processing delay
  typedef enum logic {
    DSRC_RANDOM = 1'b0,
    DSRC_PORT   = 1'b1
  } dly_src_e;

endpackage

// File: rtl/pra_lfsr.sv
// Free-running Fibonacci LFSR used as the internal delay source.
module pra_lfsr #(
  parameter int          W     = 8,
  parameter int          OUT_W = 4,
  parameter logic [W-1:0] SEED = 'h5A
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd_o
);

  logic [W-1:0] state_q;
  logic         fb;

  generate
    if (W == 16) begin : g_taps16
      assign fb = state_q[15] ^ state_q[14] ^ state_q[12] ^ state_q[3];
    end else begin : g_taps8
      assign fb = state_q[7] ^ state_q[5] ^ state_q[4] ^ state_q[3];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= {state_q[W-2:0], fb};
  end

  assign rnd_o = state_q[OUT_W-1:0];

  // R8: the generator never locks up in the all-zero state
  a_r8_lfsr_alive: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

endmodule

// File: rtl/pra_fifo.sv
// Request queue: one delay word per pending request, distributed-RAM style.
module pra_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 4,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) wr_ptr <= ptr_next(wr_ptr);
      if (pop_i)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign rdata_o = mem[rd_ptr];
  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
  assign count_o = count_q;

  // R6: occupancy bounded by the queue depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));
  // R6: the top never pushes into a full queue
  a_r6_no_push_full: assert property (@(posedge clk) disable iff (rst)
    push_i |-> !full_o);
  // R2: a pop always removes a real entry
  a_r2_pop_not_empty: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> !empty_o);
  // R5: simultaneous push and pop leave the count unchanged
  a_r5_pushpop_hold: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i) |=> $stable(count_q));

endmodule

// File: rtl/pra_sched.sv
// Head-of-queue delay timer and acknowledge spacing.
module pra_sched #(
  parameter int MAX_DLY = 10,
  parameter int GAP     = 3,
  parameter int DW      = $clog2(MAX_DLY + 1),
  parameter int GW      = $clog2(GAP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          head_vld_i,
  input  logic [DW-1:0] head_dly_i,
  output logic          pop_o,
  output logic          ack_o
);

  logic          armed_q;
  logic [DW-1:0] wait_q;
  logic [GW-1:0] gap_q;
  logic          fire;

  assign fire  = armed_q && (wait_q == '0) && (gap_q == '0);
  assign pop_o = fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      wait_q  <= '0;
      gap_q   <= '0;
      ack_o   <= 1'b0;
    end else begin
      ack_o <= fire;
      if (fire) begin
        armed_q <= 1'b0;
      end else if (!armed_q && head_vld_i) begin
        armed_q <= 1'b1;
        wait_q  <= head_dly_i;
      end else if (armed_q && wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end
      if (fire)            gap_q <= GW'(GAP - 1);
      else if (gap_q != 0) gap_q <= gap_q - 1'b1;
    end
  end

  // Independent cycles-since-ack counter used only by the checks below
  logic [GW:0] since_q;
  always_ff @(posedge clk) begin
    if (rst)                        since_q <= (GW+1)'(GAP);
    else if (ack_o)                 since_q <= (GW+1)'(1);
    else if (since_q < (GW+1)'(GAP)) since_q <= since_q + 1'b1;
  end

  // R1: acknowledges start at least GAP cycles apart
  a_r1_ack_spacing: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> since_q >= (GW+1)'(GAP));
  // R1: acknowledge pulses are one cycle wide
  a_r1_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);
  // R4: the running delay never exceeds the limit
  a_r4_wait_bound: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> wait_q <= DW'(MAX_DLY));
  // R2: a pop only happens with an entry at the head
  a_r2_pop_has_head: assert property (@(posedge clk) disable iff (rst)
    pop_o |-> head_vld_i);

endmodule

// File: rtl/pulse_ack_responder.sv
module pulse_ack_responder #(
  parameter int          DEPTH   = 32,
  parameter int          MAX_DLY = 10,
  parameter int          GAP     = 3,
  parameter int          LFSR_W  = 8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 'h5A,
  parameter int          DLY_W   = $clog2(MAX_DLY + 1),
  parameter int          CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             dly_sel_i,
  input  logic [DLY_W-1:0] dly_ext_i,
  output logic             ack_o,
  output logic [CNT_W-1:0] pending_o,
  output logic             err_o
);
  import pra_pkg::*;

  localparam logic [DLY_W-1:0] MAXV = DLY_W'(MAX_DLY);
  localparam logic [DLY_W-1:0] WRAP = DLY_W'(MAX_DLY + 1);

  logic [DLY_W-1:0] rnd, rnd_fold, ext_clamp, dly_pick;
  logic             push, pop, full, empty;
  logic [DLY_W-1:0] head_dly;
  dly_src_e         src;

  pra_lfsr #(.W(LFSR_W), .OUT_W(DLY_W), .SEED(LFSR_SEED)) i_lfsr (
    .clk(clk), .rst(rst), .rnd_o(rnd)
  );

  // Fold the raw random value into 0..MAX_DLY, clamp the port value
  always_comb begin
    rnd_fold = rnd;
    if (rnd_fold > MAXV) rnd_fold = rnd_fold - WRAP;
    if (rnd_fold > MAXV) rnd_fold = MAXV;
    ext_clamp = (dly_ext_i > MAXV) ? MAXV : dly_ext_i;
    src       = dly_src_e'(dly_sel_i);
    dly_pick  = (src == DSRC_PORT) ? ext_clamp : rnd_fold;
  end

  assign push = req_i && !full;

  pra_fifo #(.DEPTH(DEPTH), .DW(DLY_W)) i_fifo (
    .clk(clk), .rst(rst),
    .push_i(push), .wdata_i(dly_pick),
    .pop_i(pop), .rdata_o(head_dly),
    .empty_o(empty), .full_o(full), .count_o(pending_o)
  );

  pra_sched #(.MAX_DLY(MAX_DLY), .GAP(GAP), .DW(DLY_W)) i_sched (
    .clk(clk), .rst(rst),
    .head_vld_i(!empty), .head_dly_i(head_dly),
    .pop_o(pop), .ack_o(ack_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                err_o <= 1'b0;
    else if (req_i && full) err_o <= 1'b1;
  end

  // R6: the error flag is sticky until reset
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
  // R6: a request into a full queue raises the flag
  a_r6_drop_flags: assert property (@(posedge clk) disable iff (rst)
    (req_i && pending_o == CNT_W'(DEPTH)) |=> err_o);
  // R7: nothing leaves the block after a reset edge
  a_r7_reset_quiet: assert property (@(posedge clk)
    rst |=> (!ack_o && pending_o == '0 && !err_o));
  // R4: the selected delay is always in range
  a_r4_pick_range: assert property (@(posedge clk) disable iff (rst)
    dly_pick <= MAXV);

endmodule

// File: tb/test_pulse_ack_responder.sv
module test_pulse_ack_responder;
  localparam int DEPTH = 32;
  localparam int MAXD  = 10;
  localparam int DW    = 4;
  localparam int CW    = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          sel = 1'b1;
  logic [DW-1:0] dext = '0;
  logic          ack;
  logic [CW-1:0] pend;
  logic          err;

  pulse_ack_responder i_pulse_ack_responder (
    .clk(clk), .rst(rst), .req_i(req), .dly_sel_i(sel), .dly_ext_i(dext),
    .ack_o(ack), .pending_o(pend), .err_o(err)
  );

  always #5 clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  string ph = "R7";
  bit    done = 0;

  // model state
  int q_arr[$];
  int q_d[$];
  int a_prev = -100;
  int last_ack = -100;
  bit m_err = 0;
  int cyc = 0;
  bit p_req = 0, p_rst = 1, p_sel = 1;
  int p_dly = 0;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", rq, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit exp_ack;
    bit full;
    int m, e;
    cyc++;
    exp_ack = 0;
    if (p_rst) begin
      q_arr.delete(); q_d.delete();
      a_prev = -100; last_ack = -100; m_err = 0;
    end else begin
      full = (q_arr.size() == DEPTH);
      if (q_arr.size() > 0) begin
        m = imax(q_arr[0] + 1, a_prev);
        if (q_d[0] >= 0) begin
          e = imax(m + q_d[0] + 2, a_prev + 3);
          exp_ack = (e == cyc);
        end else begin
          exp_ack = ack;
          if (ack)  // R4 R8: internal delay within 0..MAXD
            chk((cyc >= m + 2) && (cyc <= m + MAXD + 2 || cyc == a_prev + 3),
                "R4", "random delay window", cyc - m - 2, 0);
        end
        if (exp_ack) begin
          void'(q_arr.pop_front()); void'(q_d.pop_front());
          a_prev = cyc;
        end
      end
      if (p_req) begin
        if (full) m_err = 1;
        else begin
          q_arr.push_back(cyc - 1);
          q_d.push_back(p_sel ? ((p_dly > MAXD) ? MAXD : p_dly) : -1);
        end
      end
    end
    chk(ack === exp_ack, p_rst ? "R7" : ph, "ack_o", int'(ack), int'(exp_ack));
    chk(pend === CW'(q_arr.size()), p_rst ? "R7" : "R5", "pending_o", int'(pend), q_arr.size());
    chk(err === m_err, p_rst ? "R7" : "R6", "err_o", int'(err), int'(m_err));
    if (ack === 1'b1) begin
      chk(cyc - last_ack >= 3, "R1", "ack spacing", cyc - last_ack, 3);
      last_ack = cyc;
    end
    p_req = req; p_rst = rst; p_sel = sel; p_dly = int'(dext);
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pulse(int d);
    @(posedge clk); #1 req = 1'b1; dext = DW'(d);
    @(posedge clk); #1 req = 1'b0;
    @(posedge clk);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    idle(4); #1 rst = 1'b0;
    ph = "R3";
    pulse(0);  idle(8);
    pulse(5);  idle(12);
    pulse(10); idle(16);
    ph = "R4";                      // clamped external values
    pulse(15); idle(16);
    pulse(12); idle(16);
    ph = "R1";                      // spacing-limited stream
    for (int i = 0; i < 6; i++) pulse(0);
    idle(12);
    ph = "R2";                      // mixed delays, ordering, push/pop overlap
    pulse(3); pulse(0); pulse(7); pulse(1); pulse(9); pulse(2); pulse(0); pulse(4);
    for (int i = 0; i < 8; i++) pulse(2);
    idle(40);
    ph = "R6";                      // overflow and sticky flag
    for (int i = 0; i < 48; i++) pulse(10);
    idle(480);
    ph = "R7";                      // reset with work pending
    for (int i = 0; i < 5; i++) pulse(10);
    idle(3);
    #1 rst = 1'b1; idle(3); #1 rst = 1'b0;
    pulse(0); idle(10);
    ph = "R8";                      // internal delay source
    #1 sel = 1'b0;
    for (int i = 0; i < 20; i++) pulse(15);
    idle(300);
    #1 sel = 1'b1;
    idle(4);
    chk(pend === '0, "R2", "drained", int'(pend), 0);
    done = 1;
    report();
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

endmodule